// File: doc/BRIEF.md
# Tuner Synthesizer Serial Control Interface

This block is the control port of a frequency-synthesizer front end. An external controller drives three wires: a chip enable, a serial clock and a serial data line. It also receives one data-out line with an output enable. Every frame opens with a four-bit address header, sent A0 first. The header picks one of three things. It can pick a write frame, which is 24, 32 or 40 bits long counting the header. It can pick a readback frame, which returns the intermediate-frequency counter result and status. Any other header is ignored. The serial pins are oversampled in the system clock domain through a synchronizer chain, and the data bits are taken on the serial-clock rising edge.

A write frame is committed only when chip enable falls after exactly the number of bits its header asks for. The header's A1 bit chooses which of two loop registers receives the data. Each loop register holds a 16-bit divide value and a 2-bit charge-pump current code. The register-select pin chooses which of the two stored loop registers drives the loop outputs. The longer frames also reload the band fields and the initialization fields. Each commit raises `update_o` for one clock, which the IF counter sequencer uses to restart.

The data-out line has three states. During a readback frame it returns the counter result and status. When the busy-indication control bit is set and no frame is in progress, it continuously drives the inverted busy flag. Otherwise it is released.

Top module: `tuner_serial_ctl`

## Requirements
- R1: A frame whose header is A0=0, A2=0, A3=1, committed after exactly 24 bits, loads the chosen loop register. The payload bits after the header are D0..D15 as the divide value (LSB first), D16 as current bit 0 and D17 as current bit 1. D18 and D19 are ignored.
- R2: Header bit A1 selects the destination of every write frame: A1=0 loads loop register 1 and A1=1 loads loop register 2. The other register keeps its value.
- R3: With `reg_sel_i` low, `div_o`/`cur_o` show loop register 1. With it high, they show loop register 2.
- R4: A header with A0=0, A2=1, A3=0, committed after exactly 32 bits, loads the chosen loop register and also the band fields: D18 `am_sel_o`, D19 `opsel_o`, D20..D22 `ref_sel_o` (LSB first), D23..D24 `gate_sel_o` (LSB first), D25 `count_start_o`. D26 and D27 are ignored.
- R5: A header with A0=0, A2=1, A3=1, committed after exactly 40 bits, loads the loop register and the band fields, and also the setup fields: D26 `xtal_sel_o`, D27 `osc_en_o`, D28 the busy-indication control bit, D29..D30 `gp_dir_o`, D31..D32 `gp_val_o`. D33..D35 are ignored.
- R6: If chip enable falls after more or fewer bits than the header requires, nothing changes and `update_o` stays low.
- R7: Each committed write frame raises `update_o` for exactly one clock cycle.
- R8: The header A0=1, A1=0, A2=0, A3=0 starts a readback. After the fourth rising serial-clock edge, `dout_oe_o` is high and `dout_o` shows counter bit 0. Each later rising edge moves to the next bit. The order is counter bits 0..CNT_W-1, then overflow, then busy, then `gp_in_i[0]`, then `gp_in_i[1]`. All of these values are captured at the fourth edge.
- R9: The readback ends when chip enable falls, and `dout_oe_o` then goes low.
- R10: While chip enable is high and no readback is active, `dout_oe_o` is low, even when the busy-indication bit is set.
- R11: With the busy-indication bit set and chip enable low, `dout_oe_o` is high and `dout_o` is the inverse of `cnt_busy_i`: 0 while counting, 1 when counting has ended.
- R12: After reset, every field output is 0. This makes both general-purpose pins inputs and leaves the oscillator select and oscillator output off. The busy-indication bit is 0, `dout_oe_o` is low and `update_o` is low.
- R13: A frame whose header is neither a write nor a readback header (for example all zeros) changes no output and drives nothing, whatever its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Serial chip enable (frame window) |
| ck_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial data in |
| reg_sel_i | input | 1 | Loop register select (0: register 1, 1: register 2) |
| cnt_value_i | input | CNT_W | IF counter result |
| cnt_over_i | input | 1 | IF counter overflow flag |
| cnt_busy_i | input | 1 | IF counter busy flag (1 = counting) |
| gp_in_i | input | 2 | Levels on the two general-purpose pins |
| dout_o | output | 1 | Serial data out value |
| dout_oe_o | output | 1 | Serial data out drive enable |
| div_o | output | 16 | Divide value of the selected loop register |
| cur_o | output | 2 | Charge-pump current code of the selected loop register |
| am_sel_o | output | 1 | Band input select |
| opsel_o | output | 1 | Pump / amplifier path select |
| ref_sel_o | output | 3 | Reference divider select |
| gate_sel_o | output | 2 | IF counter gate time select |
| count_start_o | output | 1 | IF counter start bit |
| xtal_sel_o | output | 1 | Crystal frequency select |
| osc_en_o | output | 1 | Oscillator output buffer enable |
| gp_dir_o | output | 2 | General-purpose pin direction (1 = output) |
| gp_val_o | output | 2 | General-purpose pin output level |
| update_o | output | 1 | One-cycle strobe on each committed write frame |

## Verification
Each serial pin passes through SYNC_STAGES flops, and then one more flop feeds its edge detector. A data bit therefore lands on the (SYNC_STAGES+1)-th clock edge after its serial-clock rise. A readback bit appears on `dout_o` on that same edge. A commit takes one more edge: the register fields and `update_o` change together SYNC_STAGES+2 edges after chip enable falls. The bench holds every serial phase for six clocks, more than that four-edge default latency. It drives on falling clock edges and samples outputs only on falling edges at the end of a phase. It counts `update_o` pulses and their width on rising edges, so each check sees a settled value.

// File: rtl/tuner_serial_ctl_pkg.sv
`timescale 1ns/1ps
package tuner_serial_ctl_pkg;
   // header and frame lengths (length counts the header bits)
   localparam int ADDR_BITS = 4;
   localparam int LEN_FREQ  = 24;
   localparam int LEN_BAND  = 32;
   localparam int LEN_INIT  = 40;

   // payload layout, packed without gaps
   localparam int DIV_W     = 16;
   localparam int CUR_W     = 2;
   localparam int LOOP_W    = DIV_W + CUR_W;
   localparam int BAND_W    = 8;
   localparam int SETUP_W   = 7;
   localparam int BAND_LSB  = LOOP_W;
   localparam int SETUP_LSB = BAND_LSB + BAND_W;
   localparam int PAYLOAD_W = SETUP_LSB + SETUP_W;
   localparam int PIDX_W    = $clog2(PAYLOAD_W);
   localparam int AIDX_W    = $clog2(ADDR_BITS);
   localparam int BITCNT_W  = $clog2(LEN_INIT + 1) + 1;
   localparam int NUM_SETS  = 2;

   // readback header, bit k holds Ak
   localparam logic [ADDR_BITS-1:0] READ_HDR = 4'b0001;

   typedef enum logic [1:0] {FR_NONE, FR_FREQ, FR_BAND, FR_INIT} frame_kind_e;

   typedef struct packed {
      logic [CUR_W-1:0] cur;
      logic [DIV_W-1:0] div;
   } loop_word_t;

   typedef struct packed {
      logic       start;
      logic [1:0] gate;
      logic [2:0] ref_sel;
      logic       opsel;
      logic       am_sel;
   } band_word_t;

   typedef struct packed {
      logic [1:0] gp_val;
      logic [1:0] gp_dir;
      logic       doc;
      logic       osc_en;
      logic       xtal_sel;
   } setup_word_t;

   function automatic frame_kind_e kind_of(input logic [ADDR_BITS-1:0] hdr);
      frame_kind_e k;
      k = FR_NONE;
      if (!hdr[0]) begin
         case ({hdr[2], hdr[3]})
            2'b01:   k = FR_FREQ;
            2'b10:   k = FR_BAND;
            2'b11:   k = FR_INIT;
            default: k = FR_NONE;
         endcase
      end
      return k;
   endfunction

   function automatic int unsigned len_of(input frame_kind_e k);
      case (k)
         FR_FREQ: return LEN_FREQ;
         FR_BAND: return LEN_BAND;
         FR_INIT: return LEN_INIT;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/tsc_sync.sv
`timescale 1ns/1ps
module tsc_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   localparam int CHAIN_W = W * STAGES;

   logic [CHAIN_W-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tsc_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[CHAIN_W-W-1:0], d_i};
   end

   assign q_o = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/tsc_frame_rx.sv
`timescale 1ns/1ps
module tsc_frame_rx
   import tuner_serial_ctl_pkg::*;
(
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 ce_i,
   input  logic                 ce_rise_i,
   input  logic                 ce_fall_i,
   input  logic                 ck_rise_i,
   input  logic                 din_i,
   output logic [PAYLOAD_W-1:0] payload_o,
   output frame_kind_e          kind_o,
   output logic                 sel_o,
   output logic                 commit_o,
   output logic                 read_go_o
);
   logic [BITCNT_W-1:0]  cnt_q;
   logic [ADDR_BITS-1:0] hdr_q;
   logic [PAYLOAD_W-1:0] pay_q;
   logic [BITCNT_W-1:0]  pidx;
   logic                 take;
   logic                 commit_q;
   frame_kind_e          kind;

   assign pidx = cnt_q - BITCNT_W'(ADDR_BITS);
   assign take = ce_i & ck_rise_i;
   assign kind = kind_of(hdr_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         hdr_q <= '0;
         pay_q <= '0;
      end else if (ce_rise_i) begin
         cnt_q <= '0;
         hdr_q <= '0;
         pay_q <= '0;
      end else if (take) begin
         if (cnt_q < BITCNT_W'(ADDR_BITS))
            hdr_q[cnt_q[AIDX_W-1:0]] <= din_i;
         else if (pidx < BITCNT_W'(PAYLOAD_W))
            pay_q[pidx[PIDX_W-1:0]] <= din_i;
         if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end
   end

   // a write frame counts only when its length is exact
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) commit_q <= 1'b0;
      else commit_q <= ce_fall_i && (kind != FR_NONE)
                       && (cnt_q == BITCNT_W'(len_of(kind)));
   end

   assign read_go_o = take && (cnt_q == BITCNT_W'(ADDR_BITS - 1))
                      && ({din_i, hdr_q[ADDR_BITS-2:0]} == READ_HDR);
   assign payload_o = pay_q;
   assign kind_o    = kind;
   assign sel_o     = hdr_q[1];
   assign commit_o  = commit_q;
endmodule

// File: rtl/tsc_regbank.sv
`timescale 1ns/1ps
module tsc_regbank
   import tuner_serial_ctl_pkg::*;
(
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 commit_i,
   input  frame_kind_e          kind_i,
   input  logic                 sel_i,
   input  logic [PAYLOAD_W-1:0] payload_i,
   input  logic                 reg_sel_i,
   output loop_word_t           loop_o,
   output band_word_t           band_o,
   output setup_word_t          setup_o,
   output logic                 update_o
);
   loop_word_t  set_w [NUM_SETS];
   band_word_t  band_q;
   setup_word_t setup_q;
   logic        update_q;

   generate
      for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
         loop_word_t word_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) word_q <= '0;
            else if (commit_i && (sel_i == g[0]))
               word_q <= '{cur: payload_i[DIV_W +: CUR_W],
                           div: payload_i[0 +: DIV_W]};
         end
         assign set_w[g] = word_q;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         band_q   <= '0;
         setup_q  <= '0;
         update_q <= 1'b0;
      end else begin
         update_q <= commit_i;
         if (commit_i && (kind_i == FR_BAND || kind_i == FR_INIT))
            band_q <= band_word_t'(payload_i[BAND_LSB +: BAND_W]);
         if (commit_i && kind_i == FR_INIT)
            setup_q <= setup_word_t'(payload_i[SETUP_LSB +: SETUP_W]);
      end
   end

   assign loop_o   = set_w[reg_sel_i];
   assign band_o   = band_q;
   assign setup_o  = setup_q;
   assign update_o = update_q;
endmodule

// File: rtl/tsc_dout.sv
`timescale 1ns/1ps
module tsc_dout #(
   parameter int SNAP_W = 24
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ce_i,
   input  logic              ck_rise_i,
   input  logic              read_go_i,
   input  logic [SNAP_W-1:0] snap_i,
   input  logic              doc_i,
   input  logic              busy_i,
   output logic              active_o,
   output logic              dout_o,
   output logic              oe_o
);
   logic              active_q;
   logic [SNAP_W-1:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         sh_q     <= '0;
      end else if (!ce_i) begin
         active_q <= 1'b0;
      end else if (read_go_i) begin
         active_q <= 1'b1;
         sh_q     <= snap_i;
      end else if (active_q && ck_rise_i) begin
         sh_q     <= sh_q >> 1;
      end
   end

   assign oe_o     = active_q | (doc_i & ~ce_i);
   assign dout_o   = oe_o & (active_q ? sh_q[0] : ~busy_i);
   assign active_o = active_q;
endmodule

// File: rtl/tuner_serial_ctl.sv
`timescale 1ns/1ps
module tuner_serial_ctl
   import tuner_serial_ctl_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 20
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ce_i,
   input  logic             ck_i,
   input  logic             din_i,
   input  logic             reg_sel_i,
   input  logic [CNT_W-1:0] cnt_value_i,
   input  logic             cnt_over_i,
   input  logic             cnt_busy_i,
   input  logic [1:0]       gp_in_i,
   output logic             dout_o,
   output logic             dout_oe_o,
   output logic [15:0]      div_o,
   output logic [1:0]       cur_o,
   output logic             am_sel_o,
   output logic             opsel_o,
   output logic [2:0]       ref_sel_o,
   output logic [1:0]       gate_sel_o,
   output logic             count_start_o,
   output logic             xtal_sel_o,
   output logic             osc_en_o,
   output logic [1:0]       gp_dir_o,
   output logic [1:0]       gp_val_o,
   output logic             update_o
);
   localparam int SNAP_W = CNT_W + 4;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (PAYLOAD_W > LEN_INIT - ADDR_BITS) begin : g_bad_layout
         $error("payload layout exceeds the longest frame");
      end
      if (DIV_W != 16 || CUR_W != 2) begin : g_bad_loop
         $error("loop word widths do not match the port widths");
      end
   endgenerate

   logic [2:0]           pins_s;
   logic                 ce_s, ck_s, din_s;
   logic                 ce_d, ck_d;
   logic                 ce_rise, ce_fall, ck_rise;
   logic [PAYLOAD_W-1:0] payload;
   frame_kind_e          kind;
   logic                 sel, commit, read_go, rd_active;
   loop_word_t           loop_w;
   band_word_t           band_w;
   setup_word_t          setup_w;
   logic                 doc_w;

   tsc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({din_i, ck_i, ce_i}),
      .q_o    (pins_s)
   );

   assign {din_s, ck_s, ce_s} = pins_s;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ce_d <= 1'b0;
         ck_d <= 1'b0;
      end else begin
         ce_d <= ce_s;
         ck_d <= ck_s;
      end
   end

   assign ce_rise = ce_s & ~ce_d;
   assign ce_fall = ~ce_s & ce_d;
   assign ck_rise = ck_s & ~ck_d;

   tsc_frame_rx u_rx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ce_i      (ce_s),
      .ce_rise_i (ce_rise),
      .ce_fall_i (ce_fall),
      .ck_rise_i (ck_rise),
      .din_i     (din_s),
      .payload_o (payload),
      .kind_o    (kind),
      .sel_o     (sel),
      .commit_o  (commit),
      .read_go_o (read_go)
   );

   tsc_regbank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .commit_i  (commit),
      .kind_i    (kind),
      .sel_i     (sel),
      .payload_i (payload),
      .reg_sel_i (reg_sel_i),
      .loop_o    (loop_w),
      .band_o    (band_w),
      .setup_o   (setup_w),
      .update_o  (update_o)
   );

   tsc_dout #(.SNAP_W(SNAP_W)) u_dout (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ce_i      (ce_s),
      .ck_rise_i (ck_rise),
      .read_go_i (read_go),
      .snap_i    ({gp_in_i[1], gp_in_i[0], cnt_busy_i, cnt_over_i, cnt_value_i}),
      .doc_i     (doc_w),
      .busy_i    (cnt_busy_i),
      .active_o  (rd_active),
      .dout_o    (dout_o),
      .oe_o      (dout_oe_o)
   );

   assign doc_w         = setup_w.doc;
   assign div_o         = loop_w.div;
   assign cur_o         = loop_w.cur;
   assign am_sel_o      = band_w.am_sel;
   assign opsel_o       = band_w.opsel;
   assign ref_sel_o     = band_w.ref_sel;
   assign gate_sel_o    = band_w.gate;
   assign count_start_o = band_w.start;
   assign xtal_sel_o    = setup_w.xtal_sel;
   assign osc_en_o      = setup_w.osc_en;
   assign gp_dir_o      = setup_w.gp_dir;
   assign gp_val_o      = setup_w.gp_val;
endmodule

// File: rtl/tuner_serial_ctl_chk.sv
`timescale 1ns/1ps
module tuner_serial_ctl_chk (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        ce_s,
   input logic        ce_fall,
   input logic        rd_active,
   input logic        doc_w,
   input logic        reg_sel_i,
   input logic        cnt_busy_i,
   input logic        dout_o,
   input logic        dout_oe_o,
   input logic        update_o,
   input logic [15:0] div_o,
   input logic [1:0]  cur_o,
   input logic [1:0]  gp_dir_o
);
   // R7: the strobe never lasts two cycles
   a_r7_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      update_o |=> !update_o);

   // R6: a strobe follows a chip-enable fall two edges earlier
   a_r6_strobe_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      update_o |-> $past(ce_fall, 2));

   // R1: loop outputs move only with a commit or a select change
   a_r1_loop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!update_o && $stable(reg_sel_i)) |-> ($stable(div_o) && $stable(cur_o)));

   // R9: readback ends after chip enable falls
   a_r9_read_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ce_fall |=> !rd_active);

   // R10: released during a frame that is not a readback
   a_r10_quiet_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ce_s && !rd_active) |-> !dout_oe_o);

   // R11: idle busy indication
   a_r11_busy_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (doc_w && !ce_s && !rd_active) |-> (dout_oe_o && (dout_o == !cnt_busy_i)));

   // R12: reset state
   a_r12_reset_state: assert property (@(posedge clk_i)
      !rst_ni |-> (!update_o && !dout_oe_o && gp_dir_o == 2'b00));
endmodule

bind tuner_serial_ctl tuner_serial_ctl_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .ce_s       (ce_s),
   .ce_fall    (ce_fall),
   .rd_active  (rd_active),
   .doc_w      (doc_w),
   .reg_sel_i  (reg_sel_i),
   .cnt_busy_i (cnt_busy_i),
   .dout_o     (dout_o),
   .dout_oe_o  (dout_oe_o),
   .update_o   (update_o),
   .div_o      (div_o),
   .cur_o      (cur_o),
   .gp_dir_o   (gp_dir_o)
);

// File: tb/tuner_serial_ctl_tb_top.sv
`timescale 1ns/1ps
module tuner_serial_ctl_tb_top;
   localparam int H = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce = 1'b0, ck = 1'b0, din = 1'b0, reg_sel = 1'b0;
   logic [19:0] cnt_value = '0;
   logic        cnt_over = 1'b0, cnt_busy = 1'b0;
   logic [1:0]  gp_in = 2'b00;
   logic        dout, dout_oe, am_sel, opsel, count_start, xtal_sel, osc_en, update;
   logic [15:0] div;
   logic [1:0]  cur, gate_sel, gp_dir, gp_val;
   logic [2:0]  ref_sel;

   int checks = 0;
   int errors = 0;
   int upd_cnt = 0;
   int upd_wide = 0;
   logic upd_prev = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tuner_serial_ctl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .ck_i(ck), .din_i(din),
      .reg_sel_i(reg_sel), .cnt_value_i(cnt_value), .cnt_over_i(cnt_over),
      .cnt_busy_i(cnt_busy), .gp_in_i(gp_in), .dout_o(dout), .dout_oe_o(dout_oe),
      .div_o(div), .cur_o(cur), .am_sel_o(am_sel), .opsel_o(opsel),
      .ref_sel_o(ref_sel), .gate_sel_o(gate_sel), .count_start_o(count_start),
      .xtal_sel_o(xtal_sel), .osc_en_o(osc_en), .gp_dir_o(gp_dir),
      .gp_val_o(gp_val), .update_o(update)
   );

   always @(posedge clk) begin
      if (update) upd_cnt <= upd_cnt + 1;
      if (update && upd_prev) upd_wide <= upd_wide + 1;
      upd_prev <= update;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // header codes, bit k holds Ak
   function automatic logic [3:0] hdr_freq(input logic a1); return {1'b1, 1'b0, a1, 1'b0}; endfunction
   function automatic logic [3:0] hdr_band(input logic a1); return {1'b0, 1'b1, a1, 1'b0}; endfunction
   function automatic logic [3:0] hdr_init(input logic a1); return {1'b1, 1'b1, a1, 1'b0}; endfunction

   function automatic logic [32:0] mk_pay(
      input logic [15:0] d, input logic [1:0] c, input logic am, input logic op,
      input logic [2:0] rs, input logic [1:0] g, input logic st, input logic xs,
      input logic oe, input logic dc, input logic [1:0] dir, input logic [1:0] val);
      return {val, dir, dc, oe, xs, st, g, rs, op, am, c, d};
   endfunction

   task automatic ser_begin();
      @(negedge clk) ce = 1'b1;
      repeat (H) @(negedge clk);
   endtask

   task automatic ser_bit(input logic b);
      din = b;
      repeat (H) @(negedge clk);
      ck = 1'b1;
      repeat (H) @(negedge clk);
      ck = 1'b0;
   endtask

   task automatic ser_end();
      repeat (H) @(negedge clk);
      ce = 1'b0;
      repeat (3 * H) @(negedge clk);
   endtask

   task automatic send(input logic [3:0] hdr, input logic [32:0] pay, input int n);
      logic [39:0] bits;
      bits = {3'b000, pay, hdr};
      ser_begin();
      for (int i = 0; i < n; i++) ser_bit(bits[i]);
      ser_end();
   endtask

   task automatic t_reset();
      chk("R12 div", div, 0);
      chk("R12 cur", cur, 0);
      chk("R12 gp_dir inputs", gp_dir, 0);
      chk("R12 osc bits", {xtal_sel, osc_en}, 0);
      chk("R12 band", {am_sel, opsel, ref_sel, gate_sel, count_start}, 0);
      chk("R12 dout_oe", dout_oe, 0);
      chk("R12 update", upd_cnt, 0);
   endtask

   task automatic t_freq();
      int u0;
      u0 = upd_cnt;
      reg_sel = 1'b0;
      send(hdr_freq(1'b0), mk_pay(16'h1234, 2'b10, 1, 1, 3'b111, 2'b11, 1, 1, 1, 1, 2'b11, 2'b11), 24);
      chk("R1 div reg1", div, 16'h1234);
      chk("R1 cur reg1", cur, 2'b10);
      chk("R1 band untouched", {am_sel, opsel, ref_sel, gate_sel, count_start}, 0);
      chk("R7 one strobe", upd_cnt - u0, 1);
      chk("R7 strobe width", upd_wide, 0);
      send(hdr_freq(1'b1), mk_pay(16'hBEEF, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 24);
      chk("R2 reg1 kept", {cur, div}, {2'b10, 16'h1234});
      repeat (2) @(negedge clk) reg_sel = 1'b1;
      repeat (2) @(negedge clk);
      chk("R3 reg2 selected div", div, 16'hBEEF);
      chk("R3 reg2 selected cur", cur, 2'b01);
      reg_sel = 1'b0;
      repeat (2) @(negedge clk);
      chk("R3 reg1 selected", div, 16'h1234);
   endtask

   task automatic t_band();
      send(hdr_band(1'b0), mk_pay(16'h0F0F, 2'b11, 1, 0, 3'b101, 2'b10, 1, 1, 1, 1, 2'b11, 2'b11), 32);
      chk("R4 loop", {cur, div}, {2'b11, 16'h0F0F});
      chk("R4 am/opsel", {am_sel, opsel}, 2'b10);
      chk("R4 ref_sel", ref_sel, 3'b101);
      chk("R4 gate/start", {gate_sel, count_start}, 3'b101);
      chk("R4 setup untouched", {gp_val, gp_dir, osc_en, xtal_sel}, 0);
   endtask

   task automatic t_init(input logic dc);
      send(hdr_init(1'b0), mk_pay(16'h8001, 2'b00, 0, 1, 3'b010, 2'b01, 0, 1, 1, dc, 2'b10, 2'b01), 40);
      chk("R5 xtal/osc", {xtal_sel, osc_en}, 2'b11);
      chk("R5 gp_dir", gp_dir, 2'b10);
      chk("R5 gp_val", gp_val, 2'b01);
      chk("R5 band reloaded", {am_sel, opsel, ref_sel, gate_sel, count_start}, {1'b0, 1'b1, 3'b010, 2'b01, 1'b0});
      chk("R5 loop", div, 16'h8001);
   endtask

   task automatic t_bad_len();
      int u0;
      u0 = upd_cnt;
      send(hdr_freq(1'b0), mk_pay(16'h5555, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 23);
      chk("R6 short frame", div, 16'h8001);
      send(hdr_freq(1'b0), mk_pay(16'h6666, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 25);
      chk("R6 long frame", div, 16'h8001);
      send(hdr_init(1'b0), mk_pay(16'h7777, 2'b01, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 32);
      chk("R6 init cut at 32", {div, gp_dir}, {16'h8001, 2'b10});
      chk("R6 no strobe", upd_cnt - u0, 0);
   endtask

   task automatic t_unknown();
      int u0;
      u0 = upd_cnt;
      send(4'b0000, mk_pay(16'h4321, 2'b11, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0), 24);
      send(4'b0011, mk_pay(16'h4321, 2'b11, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0), 40);
      chk("R13 loop unchanged", {cur, div}, {2'b00, 16'h8001});
      chk("R13 band unchanged", {am_sel, opsel, ref_sel}, {2'b01, 3'b010});
      chk("R13 no strobe", upd_cnt - u0, 0);
      chk("R13 not driven", dout_oe, 0);
   endtask

   task automatic t_read();
      logic [23:0] exp;
      int bad;
      cnt_value = 20'hA5C3F; cnt_over = 1'b1; cnt_busy = 1'b0; gp_in = 2'b10;
      exp = {gp_in[1], gp_in[0], cnt_busy, cnt_over, cnt_value};
      bad = 0;
      ser_begin();
      for (int i = 0; i < 3; i++) ser_bit(i == 0);
      chk("R10 header phase released", dout_oe, 0);
      ser_bit(1'b0);
      cnt_value = 20'h00000; gp_in = 2'b01;
      repeat (H) @(negedge clk);
      chk("R8 readback drives", dout_oe, 1);
      for (int k = 0; k < 24; k++) begin
         if (k > 0) begin
            ck = 1'b1;
            repeat (H) @(negedge clk);
            ck = 1'b0;
            repeat (H) @(negedge clk);
         end
         chk($sformatf("R8 bit %0d", k), dout, exp[k]);
      end
      ser_end();
      chk("R9 released after CE", dout_oe, 0);
   endtask

   task automatic t_busy_pin();
      t_init(1'b1);
      cnt_busy = 1'b1;
      repeat (4) @(negedge clk);
      chk("R11 drive while counting", {dout_oe, dout}, 2'b10);
      cnt_busy = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 drive when done", {dout_oe, dout}, 2'b11);
      ser_begin();
      ser_bit(1'b0);
      chk("R10 input frame released", dout_oe, 0);
      ser_end();
      chk("R11 drive resumes", dout_oe, 1);
      t_init(1'b0);
      chk("R11 off after clear", dout_oe, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_freq();
      t_band();
      t_init(1'b0);
      t_bad_len();
      t_unknown();
      t_read();
      t_busy_pin();
      chk("R7 strobe never wide", upd_wide, 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule